// File: doc/BRIEF.md
# MFM Write Encoder with Precompensation

This block turns a serial stream of NRZ write bits into the pulse train that drives a magnetic write head under modified frequency modulation. Each bit cell lasts `SLOTS` cycles of the fast clock. A one bit gets a flux reversal in the middle of its cell. Two zero bits in a row get a reversal on the boundary between them. A boundary next to a one gets no reversal.

Every reversal is moved one step (`STEP` cycles) early or late from its nominal slot, depending on the bits around it. This offsets the peak shift that neighbouring reversals cause on readback. Where the reversals become denser, the reversal is written late. Where they become sparser, it is written early.

While `wr_gate_i` is high, the block asks for a new bit at the start of every cell. A bit is emitted one cell after it was taken, because its classification needs the following bit. Each reversal leaves as a one-cycle `wr_pulse_o`. An internal toggle turns the pulses into the write-current level `wr_level_o`, and that toggle is cleared while the gate is low.

Top module: `mfm_precomp_wr`

## Requirements
- R1: While `wr_gate_i` is high, `bit_take_o` is high in the first gated cycle and then once every `SLOTS` cycles. `wr_data_i` is sampled at the rising edge that ends each such cycle. `bit_take_o` is low while the gate is low.
- R2: A 1 bit whose previous and next bits are equal produces one pulse at cell phase `SLOTS/2+STEP`.
- R3: A 0 bit that follows a 0 bit and is followed by a 0 bit produces a boundary pulse at cell phase `STEP`.
- R4: No pulse is produced at a boundary between a 1 and a 0, or between a 0 and a 1. A bit that follows a 1 and is itself 0 produces no pulse at all.
- R5: A 1 bit preceded by 0 and followed by 1 has its centre pulse written late, at phase `SLOTS/2+2*STEP`.
- R6: A 1 bit preceded by 1 and followed by 0 has its centre pulse written early, at phase `SLOTS/2`.
- R7: A boundary pulse between two 0 bits whose following bit is 1 is written early, at phase 0.
- R8: A pulse at phase `ph` of the bit sampled at rising edge `k` is high for the cycle after edge `k+SLOTS+1+ph`. A bit is emitted only once the bit after it has been sampled.
- R9: `wr_level_o` inverts at the edge after each cycle in which `wr_pulse_o` is high while the gate is high, and holds otherwise.
- R10: Reset, or a low gate at a clock edge, clears `wr_pulse_o` and `wr_level_o` at that edge and restarts the cell count. The bit window is refilled with ones, so the first bit of a new burst has a 1 as its previous bit.
- R11: `wr_pulse_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sub-slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_gate_i | input | 1 | Write enable; low clears all state |
| wr_data_i | input | 1 | NRZ write bit, sampled at the end of a `bit_take_o` cycle |
| bit_take_o | output | 1 | Marks the cycle in which the next bit is taken |
| wr_pulse_o | output | 1 | One-cycle flux reversal pulse |
| wr_level_o | output | 1 | Write-current level after the internal toggle |

## Verification
A bit taken at rising edge `k` puts its pulses on the output after edge `k+SLOTS+1+ph`. The phase `ph` is the nominal slot shifted by the precompensation step. `bit_take_o` itself responds to the gate in the same cycle.

The driver records the edge index at which each bit is sampled. As soon as it has sent the bit that follows, it computes the due edges of that bit's pulses and queues them. The monitor samples on the falling clock edge and matches every pulse against the head of the queue by edge index. Any early, late, extra or missing pulse is therefore a failure.

The level output is tracked the same way, one edge behind each pulse.

// File: rtl/mfm_wr_pkg.sv
`timescale 1ns/1ps
package mfm_wr_pkg;
  typedef enum logic [1:0] {
    POS_EARLY = 2'd0,
    POS_NOM   = 2'd1,
    POS_LATE  = 2'd2
  } pos_e;

  typedef struct packed {
    logic prv;
    logic cur;
    logic nxt;
  } win_t;
endpackage

// File: rtl/mfm_cell_timer.sv
`timescale 1ns/1ps
module mfm_cell_timer #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  output logic          take_o,
  output logic [SW-1:0] phase_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            slot_q <= '0;
    else if (!gate_i)       slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                    slot_q <= slot_q + 1'b1;
  end

  assign take_o  = gate_i && (slot_q == '0);
  // emission phase trails the slot count by one (window shifts at slot 0)
  assign phase_o = (slot_q == '0) ? LAST : slot_q - 1'b1;
endmodule

// File: rtl/mfm_bit_window.sv
`timescale 1ns/1ps
module mfm_bit_window
  import mfm_wr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic shift_i,
  input  logic data_i,
  output win_t win_o,
  output logic ready_o
);
  localparam win_t WIN_IDLE = '{prv: 1'b1, cur: 1'b1, nxt: 1'b1};

  win_t       win_q;
  logic [1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= WIN_IDLE;
      fill_q <= '0;
    end else if (!gate_i) begin
      win_q  <= WIN_IDLE;
      fill_q <= '0;
    end else if (shift_i) begin
      win_q.prv <= win_q.cur;
      win_q.cur <= win_q.nxt;
      win_q.nxt <= data_i;
      fill_q    <= {fill_q[0], 1'b1};
    end
  end

  assign win_o   = win_q;
  assign ready_o = fill_q[1];
endmodule

// File: rtl/mfm_precomp_classify.sv
`timescale 1ns/1ps
module mfm_precomp_classify
  import mfm_wr_pkg::*;
#(
  parameter bit PRECOMP_EN = 1'b1
) (
  input  win_t win_i,
  output logic bnd_en_o,
  output pos_e bnd_pos_o,
  output logic ctr_en_o,
  output pos_e ctr_pos_o
);
  assign ctr_en_o = win_i.cur;
  assign bnd_en_o = !win_i.prv && !win_i.cur;

  if (PRECOMP_EN) begin : g_precomp
    always_comb begin
      // denser ahead -> late, sparser ahead -> early
      if (!win_i.prv && win_i.nxt)      ctr_pos_o = POS_LATE;
      else if (win_i.prv && !win_i.nxt) ctr_pos_o = POS_EARLY;
      else                              ctr_pos_o = POS_NOM;
      bnd_pos_o = win_i.nxt ? POS_EARLY : POS_NOM;
    end
  end else begin : g_plain
    logic unused_nxt;
    assign unused_nxt = win_i.nxt;
    assign ctr_pos_o  = POS_NOM;
    assign bnd_pos_o  = POS_NOM;
  end
endmodule

// File: rtl/mfm_precomp_wr.sv
`timescale 1ns/1ps
module mfm_precomp_wr
  import mfm_wr_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int STEP       = 1,
  parameter bit PRECOMP_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_gate_i,
  input  logic wr_data_i,
  output logic bit_take_o,
  output logic wr_pulse_o,
  output logic wr_level_o
);
  localparam int SW      = $clog2(SLOTS);
  localparam int BND_NOM = STEP;
  localparam int CTR_NOM = SLOTS / 2 + STEP;

  function automatic logic [SW-1:0] slot_of(input pos_e pos, input int nom);
    int v;
    case (pos)
      POS_EARLY: v = nom - STEP;
      POS_LATE:  v = nom + STEP;
      default:   v = nom;
    endcase
    return SW'(v);
  endfunction

  logic [SW-1:0] phase;
  logic          take;
  win_t          win;
  logic          ready;
  logic          bnd_en, ctr_en;
  pos_e          bnd_pos, ctr_pos;
  logic          hit;
  logic          pulse_q, level_q;

  mfm_cell_timer #(.SLOTS(SLOTS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (wr_gate_i),
    .take_o (take),
    .phase_o(phase)
  );

  mfm_bit_window u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (wr_gate_i),
    .shift_i(take),
    .data_i (wr_data_i),
    .win_o  (win),
    .ready_o(ready)
  );

  mfm_precomp_classify #(.PRECOMP_EN(PRECOMP_EN)) u_class (
    .win_i    (win),
    .bnd_en_o (bnd_en),
    .bnd_pos_o(bnd_pos),
    .ctr_en_o (ctr_en),
    .ctr_pos_o(ctr_pos)
  );

  always_comb begin
    hit = 1'b0;
    if (ready) begin
      if (bnd_en && phase == slot_of(bnd_pos, BND_NOM)) hit = 1'b1;
      if (ctr_en && phase == slot_of(ctr_pos, CTR_NOM)) hit = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      level_q <= 1'b0;
    end else if (!wr_gate_i) begin
      pulse_q <= 1'b0;
      level_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      level_q <= level_q ^ pulse_q;
    end
  end

  assign bit_take_o = take;
  assign wr_pulse_o = pulse_q;
  assign wr_level_o = level_q;
endmodule

// File: rtl/mfm_precomp_wr_chk.sv
`timescale 1ns/1ps
module mfm_precomp_wr_chk #(
  parameter int SLOTS = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_gate_i,
  input logic bit_take_o,
  input logic wr_pulse_o,
  input logic wr_level_o
);
  int   gap_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (!wr_gate_i) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (bit_take_o) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  AST_CELL_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate_i && bit_take_o && seen_q) |-> (gap_q == SLOTS - 1)); // R1
  AST_CELL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate_i && !seen_q) |-> bit_take_o); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o); // R11
  AST_GATE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_gate_i |=> (!wr_pulse_o && !wr_level_o)); // R10
  AST_LEVEL_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate_i && wr_pulse_o) |=> (wr_level_o != $past(wr_level_o))); // R9
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate_i && !wr_pulse_o) |=> $stable(wr_level_o)); // R9
endmodule

bind mfm_precomp_wr mfm_precomp_wr_chk #(.SLOTS(SLOTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_gate_i (wr_gate_i),
  .bit_take_o(bit_take_o),
  .wr_pulse_o(wr_pulse_o),
  .wr_level_o(wr_level_o)
);

// File: tb/mfm_precomp_wr_test.sv
`timescale 1ns/1ps
module mfm_precomp_wr_test;
  localparam int SLOTS = 8;
  localparam int STEP  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate = 1'b0;
  logic data = 1'b0;
  logic take, pulse, level;

  int checks = 0;
  int fails  = 0;
  int edge_n = 0;
  bit run    = 1'b0;
  bit done   = 1'b0;

  int    exp_t[$];
  string exp_r[$];

  mfm_precomp_wr #(.SLOTS(SLOTS), .STEP(STEP), .PRECOMP_EN(1'b1)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_gate_i (gate),
    .wr_data_i (data),
    .bit_take_o(take),
    .wr_pulse_o(pulse),
    .wr_level_o(level)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, expv, edge_n);
    end
  endtask

  // expected pulses of one cell from its (prev, cur, next) window
  task automatic push_cell(input int k, input bit p, input bit c, input bit n);
    if (!p && !c) begin
      exp_t.push_back(k + SLOTS + 1 + (n ? 0 : STEP));
      exp_r.push_back(n ? "R7/R8" : "R3/R8");
    end
    if (c) begin
      if (!p && n) begin
        exp_t.push_back(k + SLOTS + 1 + SLOTS/2 + 2*STEP); exp_r.push_back("R5/R8");
      end else if (p && !n) begin
        exp_t.push_back(k + SLOTS + 1 + SLOTS/2);          exp_r.push_back("R6/R8");
      end else begin
        exp_t.push_back(k + SLOTS + 1 + SLOTS/2 + STEP);   exp_r.push_back("R2/R8");
      end
    end
  endtask

  // monitor: pulse timing, single-cycle pulses, level tracking
  bit prev_pulse = 1'b0;
  bit level_m    = 1'b0;
  always @(negedge clk) begin
    if (run) begin
      if (pulse) begin
        chk(!prev_pulse, "R11", 1, 0);
        if (exp_t.size() == 0) begin
          chk(1'b0, gate ? "R4" : "R10", edge_n, -1);
        end else begin
          chk(exp_t[0] == edge_n, exp_r[0], edge_n, exp_t[0]);
          if (exp_t[0] <= edge_n) begin
            void'(exp_t.pop_front()); void'(exp_r.pop_front());
          end
        end
      end else if (exp_t.size() != 0 && exp_t[0] < edge_n) begin
        chk(1'b0, exp_r[0], -1, exp_t[0]);
        void'(exp_t.pop_front()); void'(exp_r.pop_front());
      end
      chk(level == level_m, "R9", level, level_m);
      if (!gate)      level_m = 1'b0;
      else if (pulse) level_m = ~level_m;
      prev_pulse = pulse;
    end
  end

  // driver: one burst, bits sent msb first
  task automatic send(input logic [31:0] v, input int len);
    int k_prev, g;
    bit b1, b2;
    @(posedge clk); #1 gate = 1'b1;
    g = edge_n;
    b1 = 1'b1; b2 = 1'b1;
    k_prev = 0;
    for (int i = 0; i < len; i++) begin
      int k;
      forever begin @(negedge clk); if (take) break; end
      data = v[len-1-i];
      k = edge_n + 1;
      if (i == 0) chk(k == g + 1, "R1", k, g + 1);
      else begin
        chk(k - k_prev == SLOTS, "R1", k - k_prev, SLOTS);
        push_cell(k_prev, b2, b1, v[len-1-i]);
        b2 = b1;
      end
      b1 = v[len-1-i];
      k_prev = k;
    end
    forever begin @(negedge clk); if (take) break; end
    @(posedge clk); #1 gate = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_t.size() == 0, "R8", exp_t.size(), 0);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk(!pulse && !take && !level, "R10", {pulse, take, level}, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!pulse && !level && !take, "R10", {pulse, level, take}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    run = 1'b1;
    send(32'b1111111111, 10);          // R2
    send(32'b0000000000, 10);          // R3, R10 first bit follows ones
    send(32'b1010100101, 10);          // R4
    send(32'b011011001001, 12);        // R5 R6 R7
    send(32'b0011100100011011, 16);    // mixed
    send(32'b10, 2);                   // R8 last bit never emitted
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule